// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This block runs the start-up of an amplifier control core and captures its operating configuration once per power cycle. After power-good rises and the shutdown input is released, a timed start-up window runs. At the end of that window the block latches three things: the 3-bit code that an external converter reads from a strap-resistor divider, and the two per-channel "inputs tied to ground" detect flags. From the latched values it derives the gain step, master or slave operation, the direction of the sync pin and mono operation.

The captured configuration is frozen until power-good falls. The shutdown input, strap changes and detect-flag changes cannot alter it. Shutdown only mutes and re-enables the channel outputs. The window length is a parameter in clock cycles. At the default it gives 40 ms with a 125 MHz clock.

Top module: `pwrup_cfg_seq`

## Requirements
- R1: While reset is asserted, or once power-good has been sampled low, all outputs are 0: gain_sel, slave_mode, sync_drive, mono_mode, out_en and startup_done.
- R2: startup_done is high for exactly one cycle. It rises after the STARTUP_CYCLES-th consecutive rising edge at which pwr_good and shutdown_n were both sampled high. The configuration outputs take their captured values in that same cycle.
- R3: If shutdown_n is sampled low at any edge inside the start-up window, the window count restarts. A full STARTUP_CYCLES run of edges is then needed again.
- R4: gain_sel equals strap_code[1:0] and slave_mode equals strap_code[2]. Codes 0 to 3 give master mode and codes 4 to 7 give slave mode. In both modes the gain steps 0, 1, 2 and 3 select 20, 26, 32 and 36 dB.
- R5: sync_drive is 1 (sync pin driven as an output) only when a master configuration has been captured. It is 0 when slave mode is captured and 0 when the block is unconfigured.
- R6: If exactly one bit of ch_gnd is set at capture, mono_mode is 1 and only the other channel is enabled. Bit 0 is channel A and bit 1 is channel B, and the same positions apply in out_en. If no bit or both bits are set, mono_mode is 0 and both channels are enabled.
- R7: After capture, changes on strap_code, ch_gnd and shutdown_n leave gain_sel, slave_mode, sync_drive and mono_mode unchanged until power-good falls.
- R8: With shutdown_n high, out_en shows the channel mask exactly one cycle after startup_done.
- R9: After capture, shutdown_n sampled low clears out_en at the next edge. shutdown_n sampled high restores the mask at the next edge, and startup_done is not pulsed again.
- R10: pwr_good sampled low returns the block to the unconfigured state at the next edge. A later rise of pwr_good starts a fresh window and a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_code | input | 3 | Converted strap-divider state |
| shutdown_n | input | 1 | Active-low shutdown / mute |
| ch_gnd | input | 2 | Per-channel inputs-grounded detect (bit 0 = A, bit 1 = B) |
| pwr_good | input | 1 | Supply good; low forces unconfigured state |
| gain_sel | output | 2 | Captured gain step |
| slave_mode | output | 1 | 1 = slave, 0 = master |
| sync_drive | output | 1 | 1 = sync pin drives the clock out |
| mono_mode | output | 1 | Single-channel operation captured |
| out_en | output | 2 | Per-channel output enable |
| startup_done | output | 1 | One-cycle strobe at configuration capture |

## Verification
Two functions can fall in the same cycle: completing the start-up window, and shutdown acting on the outputs.

The bench provokes this in two ways:
- It lowers shutdown_n on the very edge that would end the window. This must prevent the capture and restart the count.
- It lowers shutdown_n on the edge right after capture. Here the configuration must be held while out_en stays 0, and out_en must rise one cycle after shutdown_n is released.

A power-good drop in the middle of the window is also judged. It must restart the count from zero once power returns.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int CODE_W = 3;
  localparam int GAIN_W = CODE_W - 1;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic              slave;
    logic              mono;
    logic [NUM_CH-1:0] ch_mask;
  } pcs_cfg_t;

  function automatic pcs_cfg_t pcs_decode(input logic [CODE_W-1:0] code,
                                          input logic [NUM_CH-1:0] gnd);
    pcs_cfg_t c;
    c.gain  = code[GAIN_W-1:0];
    c.slave = code[CODE_W-1];
    if ($countones(gnd) == 1) begin
      c.mono    = 1'b1;
      c.ch_mask = ~gnd;
    end else begin
      c.mono    = 1'b0;
      c.ch_mask = '1;
    end
    return c;
  endfunction
endpackage

// File: rtl/pcs_startup_timer.sv
module pcs_startup_timer #(
  parameter int CYCLES = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic shutdown_n,
  input  logic armed,
  output logic capture,
  output logic done_q
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run     = pwr_good && shutdown_n && armed;
  assign capture = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= capture;
      if (!run || capture) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3
  window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !shutdown_n) |=> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/pcs_cfg_latch.sv
module pcs_cfg_latch
  import pcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwr_good,
  input  logic     load,
  input  pcs_cfg_t cfg_in,
  output logic     valid_q,
  output pcs_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cfg_q   <= '0;
    end else if (!pwr_good) begin
      valid_q <= 1'b0;
      cfg_q   <= '0;
    end else if (load && !valid_q) begin
      valid_q <= 1'b1;
      cfg_q   <= cfg_in;
    end
  end

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && pwr_good) |=> $stable(cfg_q));

  // R10
  pg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!valid_q && cfg_q == '0));
endmodule

// File: rtl/pcs_out_ctrl.sv
module pcs_out_ctrl
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              shutdown_n,
  input  logic              valid,
  input  pcs_cfg_t          cfg,
  output logic [GAIN_W-1:0] gain_sel,
  output logic              slave_mode,
  output logic              sync_drive,
  output logic              mono_mode,
  output logic [NUM_CH-1:0] out_en
);
  logic [NUM_CH-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             en_q <= '0;
    else if (pwr_good && shutdown_n && valid) en_q <= cfg.ch_mask;
    else                                     en_q <= '0;
  end

  assign gain_sel   = valid ? cfg.gain  : '0;
  assign slave_mode = valid & cfg.slave;
  assign mono_mode  = valid & cfg.mono;
  assign sync_drive = valid & ~cfg.slave;
  assign out_en     = en_q;

  // R9
  sd_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown_n |=> (out_en == '0));

  // R6
  mono_one_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mono_mode |-> ($countones(out_en) <= 1));
endmodule

// File: rtl/pwrup_cfg_seq.sv
module pwrup_cfg_seq
  import pcs_pkg::*;
#(
  parameter int STARTUP_CYCLES = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_code,
  input  logic              shutdown_n,
  input  logic [NUM_CH-1:0] ch_gnd,
  input  logic              pwr_good,
  output logic [GAIN_W-1:0] gain_sel,
  output logic              slave_mode,
  output logic              sync_drive,
  output logic              mono_mode,
  output logic [NUM_CH-1:0] out_en,
  output logic              startup_done
);
  logic     capture;
  logic     cfg_valid;
  pcs_cfg_t cfg_next;
  pcs_cfg_t cfg_held;

  assign cfg_next = pcs_decode(strap_code, ch_gnd);

  pcs_startup_timer #(.CYCLES(STARTUP_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .shutdown_n (shutdown_n),
    .armed      (!cfg_valid),
    .capture    (capture),
    .done_q     (startup_done)
  );

  pcs_cfg_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .load     (capture),
    .cfg_in   (cfg_next),
    .valid_q  (cfg_valid),
    .cfg_q    (cfg_held)
  );

  pcs_out_ctrl u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .shutdown_n (shutdown_n),
    .valid      (cfg_valid),
    .cfg        (cfg_held),
    .gain_sel   (gain_sel),
    .slave_mode (slave_mode),
    .sync_drive (sync_drive),
    .mono_mode  (mono_mode),
    .out_en     (out_en)
  );

  // R8
  en_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_done && shutdown_n && pwr_good) |=> (out_en != '0));

  // R10
  pg_drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (out_en == '0 && !startup_done && !sync_drive));

  // R5
  sync_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_drive |-> !slave_mode);
endmodule

// File: tb/pwrup_cfg_seq_tb.sv
module pwrup_cfg_seq_tb;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap_code = '0;
  logic       shutdown_n = 1'b0;
  logic [1:0] ch_gnd = '0;
  logic       pwr_good = 1'b0;
  logic [1:0] gain_sel;
  logic       slave_mode, sync_drive, mono_mode, startup_done;
  logic [1:0] out_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwrup_cfg_seq #(.STARTUP_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_code(strap_code), .shutdown_n(shutdown_n),
    .ch_gnd(ch_gnd), .pwr_good(pwr_good), .gain_sel(gain_sel),
    .slave_mode(slave_mode), .sync_drive(sync_drive), .mono_mode(mono_mode),
    .out_en(out_en), .startup_done(startup_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_mask(input int g);
    return (g == 1 || g == 2) ? ((~g) & 3) : 3;
  endfunction

  task automatic chk_cfg(input string req, input int code, input int g);
    chk({req, " gain"}, gain_sel, code & 3);
    chk({req, " slave"}, slave_mode, code >> 2);
    chk({req, " sync"}, sync_drive, (code >> 2) == 0 ? 1 : 0);
    chk({req, " mono"}, mono_mode, (g == 1 || g == 2) ? 1 : 0);
  endtask

  task automatic chk_idle(input string req);
    chk({req, " gain"}, gain_sel, 0);
    chk({req, " slave"}, slave_mode, 0);
    chk({req, " sync"}, sync_drive, 0);
    chk({req, " mono"}, mono_mode, 0);
    chk({req, " en"}, out_en, 0);
    chk({req, " done"}, startup_done, 0);
  endtask

  // Drop power, then run a full window with the given code and flags.
  task automatic power_cycle(input int code, input int g);
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk_idle("R10 pg off");
    strap_code = 3'(code);
    ch_gnd = 2'(g);
    shutdown_n = 1'b1;
    pwr_good = 1'b1;
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      chk("R2 no early done", startup_done, 0);
    end
    @(negedge clk);
    chk("R2 done strobe", startup_done, 1);
    chk_cfg("R4 R5 R6 capture", code, g);
    chk("R8 en not yet", out_en, 0);
    @(negedge clk);
    chk("R2 done single", startup_done, 0);
    chk("R8 en one cycle later", out_en, exp_mask(g));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 pg low");

    for (int code = 0; code < 8; code++) begin
      for (int g = 0; g < 4; g++) begin
        power_cycle(code, g);
        strap_code = ~3'(code);
        ch_gnd = ~2'(g);
        repeat (2) @(negedge clk);
        chk_cfg("R7 frozen", code, g);
        chk("R6 mask held", out_en, exp_mask(g));
        shutdown_n = 1'b0;
        @(negedge clk);
        chk("R9 mute", out_en, 0);
        chk_cfg("R7 frozen in sd", code, g);
        shutdown_n = 1'b1;
        @(negedge clk);
        chk("R9 restore", out_en, exp_mask(g));
        chk("R9 no re-done", startup_done, 0);
        chk_cfg("R7 frozen after sd", code, g);
      end
    end

    // R3: shutdown low on the edge that would end the window
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    strap_code = 3'd5; ch_gnd = 2'd0; shutdown_n = 1'b1; pwr_good = 1'b1;
    repeat (N - 1) @(negedge clk);
    shutdown_n = 1'b0;
    @(negedge clk);
    chk("R3 no capture at collision", startup_done, 0);
    chk("R3 still unconfigured", slave_mode, 0);
    shutdown_n = 1'b1;
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      chk("R3 restarted count", startup_done, 0);
    end
    @(negedge clk);
    chk("R3 done after full window", startup_done, 1);
    chk_cfg("R4 collision capture", 5, 0);
    // Collision: shutdown falls the edge after capture
    shutdown_n = 1'b0;
    @(negedge clk);
    chk("R9 en held off", out_en, 0);
    chk_cfg("R7 held in mute", 5, 0);
    shutdown_n = 1'b1;
    @(negedge clk);
    chk("R8 en after release", out_en, 3);

    // R10: power drop mid-window restarts from zero
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    strap_code = 3'd2; ch_gnd = 2'd2; pwr_good = 1'b1;
    repeat (N / 2) @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    pwr_good = 1'b1;
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      chk("R10 fresh window", startup_done, 0);
    end
    @(negedge clk);
    chk("R10 fresh capture", startup_done, 1);
    chk_cfg("R6 mono A", 2, 2);
    @(negedge clk);
    chk("R6 only A", out_en, 1);

    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule